// File: doc/BRIEF.md
# Serial Audio Transmitter for I2S and TDM Framing

This block turns 32-bit sample words into a serial audio bit stream, most significant bit first. Words arrive on a ready/valid input and wait in a one-entry holding register. An external clock and frame generator sets the pace. It sends one bit strobe per bit period, and it marks the first bit of every slot and the first slot of every frame. The transmitter counts slots from the frame marker to get the channel number. At the start of each slot it loads a new sample, resends the previous one, or sends silence.

The supported formats are the two-channel standard I2S format, left-justified, and multi-slot TDM in a delayed and an undelayed flavour. Sample lengths run from 8 to 32 bits. Two compact stereo codes pack a left and a right half into one word. A mono option doubles each sample onto the odd channel. When a slot starts with no sample waiting, the block records an underrun for that channel in sticky flags. The flags sit in two four-channel groups plus a summary bit, and each can be set or cleared by mask strobes. A loopback output carries the serial stream toward a receiver for self-test. Enable and disable commands take effect only on a frame boundary.

Top module: `i2s_tx_top`

## Requirements
- R1: After reset inReady is 1, sdOut and loopOut are 0, and every underrun flag and the summary flag are 0.
- R2: A single holding register accepts a word when inValid and inReady are both 1. inReady is 1 exactly while that register is empty. A stored word is taken at the start of the slot that uses it.
- R3: With fmt 0 (I2S) or 2 (TDM), the first bit of each slot is 0 and the sample's MSB goes out on the second bit. With fmt 1 (left-justified) or 3 (TDM left-justified), the MSB goes out on the first bit. Bits follow MSB first, and every bit after the last sample bit in the 32-bit slot is 0.
- R4: lenCode selects the sample length, taken from the low bits of the word: 0 gives 32 bits, 1 gives 24, 2 gives 20, 3 gives 18, 4 gives 16 and 6 gives 8.
- R5: lenCode 5 (16-bit compact) and 7 (8-bit compact) send word bits 15:0 or 7:0 in one slot and bits 31:16 or 15:8 in the next sending slot. inReady stays 0 between these two slots.
- R6: If a slot starts while transmission is active, no sample is held, and rule R9 does not apply, then the flag for that channel is set, along with the summary flag. The channel number is the count of slots since the frame marker, starting at 0.
- R7: On an underrun, repeatLast=1 resends the last loaded sample and repeatLast=0 sends all zeros.
- R8: urChanLo holds channels 3..0 and urChanHi holds channels 7..4, bit n for channel n of the group. Set strobes force bits to 1 and clear strobes force bits to 0. A set beats a clear in the same cycle. Channel strobes leave the summary flag alone. A flag falls only through its clear strobe.
- R9: With monoEn=1, every odd channel resends the sample of the preceding slot. It takes nothing from the holding register and flags no underrun.
- R10: enCmd and disCmd pulses take effect at the next frame marker, and disCmd wins if both are given. While inactive, the serial output is 0, no word is taken from the holding register, and no underrun is flagged.
- R11: loopOut always carries the serial stream. sdOut equals that stream while loopEn=0 and is 0 while loopEn=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitTick | input | 1 | One-cycle strobe per serial bit period |
| slotStart | input | 1 | With bitTick: this bit opens a slot |
| frameStart | input | 1 | With slotStart: this slot is channel 0 |
| fmt | input | 2 | Framing: 0 I2S, 1 left-justified, 2 TDM, 3 TDM left-justified |
| lenCode | input | 3 | Sample length / compact code (see R4, R5) |
| monoEn | input | 1 | Odd channels repeat the previous slot |
| repeatLast | input | 1 | Underrun policy: 1 repeat, 0 zeros |
| loopEn | input | 1 | Loopback test: mute sdOut |
| enCmd | input | 1 | Start transmitting at next frame |
| disCmd | input | 1 | Stop transmitting at next frame |
| inData | input | 32 | Sample word |
| inValid | input | 1 | inData is valid |
| inReady | output | 1 | Holding register empty |
| sdOut | output | 1 | Serial data to the pin |
| loopOut | output | 1 | Serial data toward the receiver |
| urSetLo | input | 4 | Set mask, channels 3..0 |
| urSetHi | input | 4 | Set mask, channels 7..4 |
| urSetSum | input | 1 | Set the summary flag |
| urClrLo | input | 4 | Clear mask, channels 3..0 |
| urClrHi | input | 4 | Clear mask, channels 7..4 |
| urClrSum | input | 1 | Clear the summary flag |
| urChanLo | output | 4 | Underrun flags, channels 3..0 |
| urChanHi | output | 4 | Underrun flags, channels 7..4 |
| urSummary | output | 1 | Any-underrun summary flag |

## Verification
The assertions assume that slotStart and frameStart are only meaningful together with bitTick. They also assume that fmt, lenCode and monoEn hold steady across a compact word's two halves. The stimulus drives strobes only as whole 32-bit slots that open with slotStart. It changes mode inputs only between slots, with no half word pending, and it sends enable and disable pulses in cycles without a bit strobe.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;
  localparam int SAMPLE_W = 32;
  localparam int CHAN_W   = 3;
  localparam int NUM_CH   = 1 << CHAN_W;
  localparam int GROUP_W  = NUM_CH / 2;

  localparam logic [1:0] FMT_I2S  = 2'd0;
  localparam logic [1:0] FMT_LJ   = 2'd1;
  localparam logic [1:0] FMT_TDM  = 2'd2;
  localparam logic [1:0] FMT_TDML = 2'd3;

  localparam logic [2:0] LEN_C16 = 3'd5;
  localparam logic [2:0] LEN_C8  = 3'd7;

  typedef struct packed {
    logic tick;       // bit period strobe
    logic slotEdge;   // first bit of a slot
    logic loadWord;   // take held word into the shifter
    logic takeHigh;   // use upper half of a compact word
    logic reuseLast;  // resend last loaded sample
    logic capture;    // accept inData into holding register
  } txStrobe_t;
endpackage

// File: rtl/i2s_tx_ctrl.sv
module i2s_tx_ctrl
  import i2s_tx_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                bitTick,
  input  logic                slotStart,
  input  logic                frameStart,
  input  logic [2:0]          lenCode,
  input  logic                monoEn,
  input  logic                repeatLast,
  input  logic                enCmd,
  input  logic                disCmd,
  input  logic                inValid,
  output logic                inReady,
  input  logic [NUM_CH-1:0]   flagSet,
  input  logic                sumSet,
  input  logic [NUM_CH-1:0]   flagClr,
  input  logic                sumClr,
  output logic [NUM_CH-1:0]   flags,
  output logic                summary,
  output txStrobe_t           strb
);
  logic              wantOn, active, holdFull, halfUsed;
  logic [CHAN_W-1:0] slotCnt, chanNow;
  logic              slotEdge, activeNow, isCompact;
  logic              loadW, high, reuse, evt, consume, setHalf, accept;
  logic [NUM_CH-1:0] evtVec;

  assign slotEdge  = bitTick && slotStart;
  assign chanNow   = frameStart ? '0 : slotCnt + 1'b1;
  assign activeNow = frameStart ? wantOn : active;
  assign isCompact = (lenCode == LEN_C16) || (lenCode == LEN_C8);
  assign accept    = inValid && !holdFull;
  assign inReady   = !holdFull;

  always_comb begin
    loadW = 1'b0; high = 1'b0; reuse = 1'b0;
    evt = 1'b0; consume = 1'b0; setHalf = 1'b0;
    if (slotEdge && activeNow) begin
      if (monoEn && chanNow[0]) begin
        reuse = 1'b1;
      end else if (halfUsed) begin
        loadW = 1'b1; high = 1'b1; consume = 1'b1;
      end else if (holdFull) begin
        loadW = 1'b1;
        if (isCompact) setHalf = 1'b1;
        else           consume = 1'b1;
      end else begin
        evt = 1'b1; reuse = repeatLast;
      end
    end
  end

  always_comb begin
    evtVec = '0;
    if (evt) evtVec[chanNow] = 1'b1;
  end

  assign strb = '{tick: bitTick, slotEdge: slotEdge, loadWord: loadW,
                  takeHigh: high, reuseLast: reuse, capture: accept};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wantOn   <= 1'b0;
      active   <= 1'b0;
      holdFull <= 1'b0;
      halfUsed <= 1'b0;
      slotCnt  <= '0;
      flags    <= '0;
      summary  <= 1'b0;
    end else begin
      if (disCmd)     wantOn <= 1'b0;
      else if (enCmd) wantOn <= 1'b1;
      if (slotEdge) begin
        slotCnt <= chanNow;
        active  <= activeNow;
      end
      if (accept)       holdFull <= 1'b1;
      else if (consume) holdFull <= 1'b0;
      if (setHalf)      halfUsed <= 1'b1;
      else if (consume) halfUsed <= 1'b0;
      flags   <= (flags & ~flagClr) | flagSet | evtVec;
      summary <= (summary & ~sumClr) | sumSet | evt;
    end
  end
endmodule

// File: rtl/i2s_tx_datapath.sv
module i2s_tx_datapath
  import i2s_tx_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  txStrobe_t           strb,
  input  logic [1:0]          fmt,
  input  logic [2:0]          lenCode,
  input  logic [SAMPLE_W-1:0] inData,
  output logic                txBit
);
  logic [SAMPLE_W-1:0] holdWord, lastSample, shifter, chosen, aligned;
  logic                delayed;

  assign delayed = (fmt == FMT_I2S) || (fmt == FMT_TDM);

  // MSB-justify the selected sample; low bits fill with zeros
  always_comb begin
    unique case (lenCode)
      3'd0:    aligned = holdWord;
      3'd1:    aligned = {holdWord[23:0], 8'b0};
      3'd2:    aligned = {holdWord[19:0], 12'b0};
      3'd3:    aligned = {holdWord[17:0], 14'b0};
      3'd4:    aligned = {holdWord[15:0], 16'b0};
      3'd5:    aligned = strb.takeHigh ? {holdWord[31:16], 16'b0}
                                       : {holdWord[15:0], 16'b0};
      3'd6:    aligned = {holdWord[7:0], 24'b0};
      default: aligned = strb.takeHigh ? {holdWord[15:8], 24'b0}
                                       : {holdWord[7:0], 24'b0};
    endcase
  end

  always_comb begin
    if (strb.loadWord)       chosen = aligned;
    else if (strb.reuseLast) chosen = lastSample;
    else                     chosen = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdWord   <= '0;
      lastSample <= '0;
      shifter    <= '0;
      txBit      <= 1'b0;
    end else begin
      if (strb.capture) holdWord <= inData;
      if (strb.tick) begin
        if (strb.slotEdge) begin
          if (strb.loadWord) lastSample <= aligned;
          txBit   <= delayed ? 1'b0 : chosen[SAMPLE_W-1];
          shifter <= delayed ? chosen : {chosen[SAMPLE_W-2:0], 1'b0};
        end else begin
          txBit   <= shifter[SAMPLE_W-1];
          shifter <= {shifter[SAMPLE_W-2:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/i2s_tx_top.sv
module i2s_tx_top
  import i2s_tx_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        bitTick,
  input  logic        slotStart,
  input  logic        frameStart,
  input  logic [1:0]  fmt,
  input  logic [2:0]  lenCode,
  input  logic        monoEn,
  input  logic        repeatLast,
  input  logic        loopEn,
  input  logic        enCmd,
  input  logic        disCmd,
  input  logic [31:0] inData,
  input  logic        inValid,
  output logic        inReady,
  output logic        sdOut,
  output logic        loopOut,
  input  logic [3:0]  urSetLo,
  input  logic [3:0]  urSetHi,
  input  logic        urSetSum,
  input  logic [3:0]  urClrLo,
  input  logic [3:0]  urClrHi,
  input  logic        urClrSum,
  output logic [3:0]  urChanLo,
  output logic [3:0]  urChanHi,
  output logic        urSummary
);
  txStrobe_t         strb;
  logic [NUM_CH-1:0] flags;
  logic              txBit;

  i2s_tx_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .slotStart(slotStart),
    .frameStart(frameStart), .lenCode(lenCode), .monoEn(monoEn),
    .repeatLast(repeatLast), .enCmd(enCmd), .disCmd(disCmd),
    .inValid(inValid), .inReady(inReady),
    .flagSet({urSetHi, urSetLo}), .sumSet(urSetSum),
    .flagClr({urClrHi, urClrLo}), .sumClr(urClrSum),
    .flags(flags), .summary(urSummary), .strb(strb)
  );

  i2s_tx_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .fmt(fmt), .lenCode(lenCode),
    .inData(inData), .txBit(txBit)
  );

  assign urChanLo = flags[GROUP_W-1:0];
  assign urChanHi = flags[NUM_CH-1:GROUP_W];
  assign loopOut  = txBit;
  assign sdOut    = txBit && !loopEn;
endmodule

// File: rtl/i2s_tx_checker.sv
module i2s_tx_checker
  import i2s_tx_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       inValid,
  input logic       inReady,
  input logic       loopOut,
  input logic [3:0] urChanLo,
  input logic [3:0] urChanHi,
  input logic       urSummary,
  input logic [3:0] urClrLo,
  input logic [3:0] urClrHi,
  input logic       urClrSum,
  input txStrobe_t  strb
);
  // R2: an accepted word fills the holder, so the next cycle is not ready
  p_accept_fills_r2: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> !inReady);

  // R7 / R10: a slot opened with neither a new nor a repeated sample starts silent
  p_silent_slot_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.tick && strb.slotEdge && !strb.loadWord && !strb.reuseLast) |=> !loopOut);

  // R8: a flag falls only where its clear strobe was given
  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    (($past({urChanHi, urChanLo, urSummary}) & ~{urChanHi, urChanLo, urSummary})
      & ~$past({urClrHi, urClrLo, urClrClean(urClrSum)})) == 9'd0);

  // R9 / R6: a slot uses at most one sample source
  p_one_source_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.loadWord, strb.reuseLast}));

  // R5: the upper compact half is only ever selected during a load
  p_high_needs_load_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.takeHigh |-> strb.loadWord);

  function automatic logic urClrClean(input logic b);
    return b;
  endfunction
endmodule

bind i2s_tx_top i2s_tx_checker u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
  .loopOut(loopOut), .urChanLo(urChanLo), .urChanHi(urChanHi),
  .urSummary(urSummary), .urClrLo(urClrLo), .urClrHi(urClrHi),
  .urClrSum(urClrSum), .strb(strb)
);

// File: tb/test_i2s_tx_top.sv
module test_i2s_tx_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        bitTick = 0, slotStart = 0, frameStart = 0;
  logic [1:0]  fmt = 2'd0;
  logic [2:0]  lenCode = 3'd0;
  logic        monoEn = 0, repeatLast = 0, loopEn = 0, enCmd = 0, disCmd = 0;
  logic [31:0] inData = '0;
  logic        inValid = 0;
  logic        inReady, sdOut, loopOut, urSummary;
  logic [3:0]  urSetLo = '0, urSetHi = '0, urClrLo = '0, urClrHi = '0;
  logic        urSetSum = 0, urClrSum = 0;
  logic [3:0]  urChanLo, urChanHi;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  i2s_tx_top i_i2s_tx_top (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .slotStart(slotStart),
    .frameStart(frameStart), .fmt(fmt), .lenCode(lenCode), .monoEn(monoEn),
    .repeatLast(repeatLast), .loopEn(loopEn), .enCmd(enCmd), .disCmd(disCmd),
    .inData(inData), .inValid(inValid), .inReady(inReady), .sdOut(sdOut),
    .loopOut(loopOut), .urSetLo(urSetLo), .urSetHi(urSetHi),
    .urSetSum(urSetSum), .urClrLo(urClrLo), .urClrHi(urClrHi),
    .urClrSum(urClrSum), .urChanLo(urChanLo), .urChanHi(urChanHi),
    .urSummary(urSummary)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Expected slot contents as seen MSB-first over 32 bit periods
  function automatic logic [31:0] expWord(input logic [31:0] s, input int len,
                                          input bit delayed);
    logic [63:0] m;
    m = (64'(s) & ((64'd1 << len) - 64'd1)) << (32 - len);
    return delayed ? (m[31:0] >> 1) : m[31:0];
  endfunction

  // All tasks start and end just after a falling edge
  task automatic runSlot(input bit first, output logic [31:0] dataW,
                         output logic [31:0] loopW);
    for (int k = 0; k < 32; k++) begin
      bitTick = 1; slotStart = (k == 0); frameStart = first && (k == 0);
      @(negedge clk);
      dataW[31-k] = sdOut;
      loopW[31-k] = loopOut;
    end
    bitTick = 0; slotStart = 0; frameStart = 0;
  endtask

  task automatic push(input logic [31:0] w, input string req);
    check(inReady === 1'b1, req, {31'b0, inReady}, 32'd1);
    inData = w; inValid = 1;
    @(negedge clk);
    inValid = 0;
  endtask

  task automatic pulseEn(input bit on);
    if (on) enCmd = 1; else disCmd = 1;
    @(negedge clk);
    enCmd = 0; disCmd = 0;
  endtask

  task automatic clearAll();
    urClrLo = '1; urClrHi = '1; urClrSum = 1;
    @(negedge clk);
    urClrLo = '0; urClrHi = '0; urClrSum = 0;
  endtask

  task automatic testReset();
    check(inReady === 1'b1, "R1 ready", {31'b0, inReady}, 32'd1);
    check(sdOut === 1'b0 && loopOut === 1'b0, "R1 serial", {30'b0, sdOut, loopOut}, 0);
    check({urChanHi, urChanLo, urSummary} === 9'd0, "R1 flags",
          {23'b0, urChanHi, urChanLo, urSummary}, 0);
  endtask

  task automatic testDisabledThenI2s();
    logic [31:0] d, l;
    fmt = 2'd0; lenCode = 3'd0;
    push(32'hA5C3_0F96, "R2 push");
    runSlot(1, d, l);
    check(d === 32'h0, "R10 idle output", d, 0);
    check(inReady === 1'b0, "R10 no consume", {31'b0, inReady}, 0);
    check({urChanHi, urChanLo, urSummary} === 9'd0, "R10 no flag",
          {23'b0, urChanHi, urChanLo, urSummary}, 0);
    pulseEn(1);
    runSlot(1, d, l);
    check(d === expWord(32'hA5C3_0F96, 32, 1), "R3 I2S delayed 32b", d,
          expWord(32'hA5C3_0F96, 32, 1));
    check(inReady === 1'b1, "R2 consumed", {31'b0, inReady}, 1);
    push(32'h8000_0001, "R2 push");
    runSlot(0, d, l);
    check(d === expWord(32'h8000_0001, 32, 1), "R3 I2S right", d,
          expWord(32'h8000_0001, 32, 1));
  endtask

  task automatic testLj24();
    logic [31:0] d, l;
    fmt = 2'd1; lenCode = 3'd1;
    push(32'hFF12_3456, "R2 push");
    runSlot(1, d, l);
    check(d === 32'h1234_5600, "R4 LJ 24b left", d, 32'h1234_5600);
    push(32'h00AB_CDEF, "R2 push");
    runSlot(0, d, l);
    check(d === 32'hABCD_EF00, "R4 LJ 24b right", d, 32'hABCD_EF00);
    lenCode = 3'd3;
    push(32'hFFFF_FFFF, "R2 push");
    runSlot(1, d, l);
    check(d === expWord(32'hFFFF_FFFF, 18, 0), "R4 18b tail zero", d,
          expWord(32'hFFFF_FFFF, 18, 0));
    push(32'h0000_0000, "R2 push");
    runSlot(0, d, l);
  endtask

  task automatic testCompact();
    logic [31:0] d, l;
    fmt = 2'd3; lenCode = 3'd5;
    push(32'hBEEF_1234, "R5 push");
    runSlot(1, d, l);
    check(d === 32'h1234_0000, "R5 c16 low half", d, 32'h1234_0000);
    check(inReady === 1'b0, "R5 held between halves", {31'b0, inReady}, 0);
    runSlot(0, d, l);
    check(d === 32'hBEEF_0000, "R5 c16 high half", d, 32'hBEEF_0000);
    check(inReady === 1'b1, "R5 freed", {31'b0, inReady}, 1);
    fmt = 2'd2; lenCode = 3'd7;
    push(32'h0000_C35A, "R5 push");
    runSlot(1, d, l);
    check(d === expWord(32'h5A, 8, 1), "R5 c8 low TDM", d, expWord(32'h5A, 8, 1));
    runSlot(0, d, l);
    check(d === expWord(32'hC3, 8, 1), "R5 c8 high TDM", d, expWord(32'hC3, 8, 1));
  endtask

  task automatic testUnderrun();
    logic [31:0] d, l;
    clearAll();
    fmt = 2'd1; lenCode = 3'd4; repeatLast = 1;
    push(32'h0000_8001, "R2 push");
    runSlot(1, d, l);
    runSlot(0, d, l);
    check(d === 32'h8001_0000, "R7 repeat last", d, 32'h8001_0000);
    check(urChanLo === 4'b0010 && urSummary, "R6 flag ch1",
          {27'b0, urSummary, urChanLo}, 32'h12);
    clearAll();
    repeatLast = 0;
    push(32'h0000_7777, "R2 push");
    runSlot(1, d, l);
    runSlot(0, d, l);
    check(d === 32'h0, "R7 zeros", d, 0);
    check(urChanLo === 4'b0010, "R6 flag ch1 zero", {28'b0, urChanLo}, 2);
  endtask

  task automatic testTdm8();
    logic [31:0] d, l;
    clearAll();
    fmt = 2'd3; lenCode = 3'd4; repeatLast = 0;
    for (int ch = 0; ch < 8; ch++) begin
      if (ch != 5) push(32'h1000 + ch, "R2 push");
      runSlot(ch == 0, d, l);
      if (ch == 5) check(d === 32'h0, "R7 ch5 silent", d, 0);
      if (ch == 6) check(d === 32'h1006_0000, "R6 ch6 data", d, 32'h1006_0000);
    end
    check(urChanHi === 4'b0010 && urChanLo === 4'b0000 && urSummary, "R6 hi group ch5",
          {23'b0, urChanHi, urChanLo, urSummary}, 9'b0010_0000_1);
  endtask

  task automatic testStrobes();
    clearAll();
    urSetLo = 4'b0101; urSetHi = 4'b1000;
    @(negedge clk);
    urSetLo = 0; urSetHi = 0;
    check(urChanLo === 4'b0101 && urChanHi === 4'b1000 && !urSummary, "R8 set",
          {23'b0, urChanHi, urChanLo, urSummary}, 9'b1000_0101_0);
    urSetLo = 4'b0001; urClrLo = 4'b0001;
    @(negedge clk);
    urSetLo = 0; urClrLo = 0;
    check(urChanLo === 4'b0101, "R8 set beats clear", {28'b0, urChanLo}, 5);
    urClrLo = 4'b0100;
    @(negedge clk);
    urClrLo = 0;
    check(urChanLo === 4'b0001 && urChanHi === 4'b1000, "R8 clear",
          {24'b0, urChanHi, urChanLo}, 8'h81);
    urSetSum = 1;
    @(negedge clk);
    urSetSum = 0;
    check(urSummary === 1'b1, "R8 summary set", {31'b0, urSummary}, 1);
    urClrSum = 1;
    @(negedge clk);
    urClrSum = 0;
    check(urSummary === 1'b0, "R8 summary clear", {31'b0, urSummary}, 0);
  endtask

  task automatic testMono();
    logic [31:0] d, l;
    clearAll();
    fmt = 2'd1; lenCode = 3'd4; monoEn = 1;
    push(32'h0000_CAFE, "R2 push");
    runSlot(1, d, l);
    check(d === 32'hCAFE_0000, "R9 mono left", d, 32'hCAFE_0000);
    check(inReady === 1'b1, "R9 consumed once", {31'b0, inReady}, 1);
    runSlot(0, d, l);
    check(d === 32'hCAFE_0000, "R9 mono right", d, 32'hCAFE_0000);
    check({urChanHi, urChanLo, urSummary} === 9'd0, "R9 no underrun",
          {23'b0, urChanHi, urChanLo, urSummary}, 0);
    monoEn = 0;
  endtask

  task automatic testLoop();
    logic [31:0] d, l;
    loopEn = 1;
    push(32'h0000_1357, "R2 push");
    runSlot(1, d, l);
    check(d === 32'h0, "R11 pin muted", d, 0);
    check(l === 32'h1357_0000, "R11 loop data", l, 32'h1357_0000);
    loopEn = 0;
    push(32'h0000_2468, "R2 push");
    runSlot(0, d, l);
    check(d === 32'h2468_0000 && l === d, "R11 pin restored", d, 32'h2468_0000);
  endtask

  task automatic testDisable();
    logic [31:0] d, l;
    clearAll();
    push(32'h0000_1111, "R2 push");
    runSlot(1, d, l);
    pulseEn(0);
    push(32'h0000_2222, "R2 push");
    runSlot(0, d, l);
    check(d === 32'h2222_0000, "R10 frame completes", d, 32'h2222_0000);
    push(32'h0000_3333, "R2 push");
    runSlot(1, d, l);
    check(d === 32'h0, "R10 stopped at frame", d, 0);
    runSlot(0, d, l);
    check(inReady === 1'b0 && urSummary === 1'b0, "R10 holds word, no flag",
          {30'b0, inReady, urSummary}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testDisabledThenI2s();
    testLj24();
    testCompact();
    testUnderrun();
    testTdm8();
    testStrobes();
    testMono();
    testLoop();
    testDisable();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule